// File: doc/BRIEF.md
# Transmit Test Pattern Generator

This block produces the serial NRZ transmit stream, one bit per clock, for a line interface that runs at the E3, DS3 or STS-1 rate. It either forwards the user's NRZ data or replaces it with a built-in test pattern. The available patterns are a constant mark stream, a mark/space alternation, a complete DS3 alarm-indication multiframe, and unframed pseudorandom sequences of length 2^15−1 and 2^23−1. The pattern comes from a 2-bit pattern select together with the rate mode. A master enable input switches the generator off and forwards user data whatever the select says.

The output is registered. Inputs sampled at a rising clock edge decide the bit that appears on `tx_bit` just after that same edge. A zero-substitution encoder and line driver sit downstream and are not part of this block.

Top module: `tpg_top`

## Requirements
- R1: While `gen_en` is 0, `tx_bit` after each rising edge equals `usr_bit` sampled at that edge, whatever `pat_sel` and `line_rate` are.
- R2: With `gen_en` = 1, `pat_sel` = 00 forwards `usr_bit` as in R1, and `pat_sel` = 01 drives `tx_bit` to 1 on every clock.
- R3: With `gen_en` = 1 and `pat_sel` = 10 at rate E3 (`line_rate` = 00) or STS-1 (`line_rate` = 10, with 11 treated as STS-1), `tx_bit` alternates 1,0,1,0… and begins with 1.
- R4: With `gen_en` = 1, `pat_sel` = 10 and rate DS3 (`line_rate` = 01), `tx_bit` sends the DS3 alarm multiframe of 4760 bits, repeated without a gap. It is 7 subframes of 8 blocks, and each block is one overhead bit followed by 84 payload bits.
- R5: In the alarm multiframe, the block overhead bits of every subframe come in the order lead bit, F1, C1, F2, C2, F3, C3, F4. F1 = F4 = 1 and F2 = F3 = 0, and all C bits are 0. The lead bits of subframes 1 to 7 are 1,1,0,0,0,1,0, and subframe 1 is sent first.
- R6: Each 84-bit payload run in the alarm multiframe is 1010…, and it starts with a 1 right after every overhead bit.
- R7: With `gen_en` = 1 and `pat_sel` = 11 at rate DS3 or STS-1, `tx_bit` is the 2^15−1 sequence with o[n] = o[n−15] XOR o[n−14], and its first 15 bits are 1.
- R8: With `gen_en` = 1 and `pat_sel` = 11 at rate E3, `tx_bit` is the 2^23−1 sequence with o[n] = o[n−23] XOR o[n−18], and its first 23 bits are 1.
- R9: A change of the selected pattern takes effect at the next edge, and the new pattern starts from its first bit (alarm at the subframe 1 lead bit). While the selection stays the same the pattern runs on unbroken. The shift registers never hold all zeros.
- R10: While `rst_n` is 0, `tx_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | 1 = honour `pat_sel`; 0 = forward user data |
| pat_sel | input | 2 | Pattern select (00 user, 01 ones, 10 alternation/alarm, 11 PRBS) |
| line_rate | input | 2 | 00 E3, 01 DS3, 10 STS-1, 11 as STS-1 |
| usr_bit | input | 1 | User NRZ data bit |
| tx_bit | output | 1 | Registered transmit NRZ bit |

## Verification
A sequencer counter that is off by one shows up as an overhead bit out of place. Inside an alarm multiframe that appears within 85 bits, or at the first multiframe wrap after 4760 bits. A wrong feedback tap in either shift register leaves the first 15 or 23 ones intact, and the output stream then differs from the recurrence within a few dozen bits. A missing restart on a pattern change is visible in the first bit after the change. The bench therefore checks every output bit against an independent model, through full multiframes, a full short PRBS period and rapid reselection.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [2:0] {
    PAT_USER  = 3'd0,
    PAT_ONES  = 3'd1,
    PAT_ALT   = 3'd2,
    PAT_ALARM = 3'd3,
    PAT_PN15  = 3'd4,
    PAT_PN23  = 3'd5
  } pat_mode_e;

  localparam logic [1:0] RATE_E3  = 2'd0;
  localparam logic [1:0] RATE_DS3 = 2'd1;

  // Effective pattern from enable, select and rate.
  function automatic pat_mode_e pick_mode(input logic en, input logic [1:0] sel,
                                          input logic [1:0] rate);
    pat_mode_e m;
    if (!en) m = PAT_USER;
    else begin
      case (sel)
        2'd0: m = PAT_USER;
        2'd1: m = PAT_ONES;
        2'd2: m = (rate == RATE_DS3) ? PAT_ALARM : PAT_ALT;
        default: m = (rate == RATE_E3) ? PAT_PN23 : PAT_PN15;
      endcase
    end
    return m;
  endfunction

  // Overhead bit of the alarm multiframe for a given subframe / block.
  function automatic logic alarm_overhead(input int sub, input int blk);
    logic [6:0] lead_bits;
    logic b;
    lead_bits = 7'b0100011;   // subframe 0 in bit 0
    case (blk)
      0:       b = lead_bits[sub];
      1, 7:    b = 1'b1;       // F1, F4
      default: b = 1'b0;       // C bits, F2, F3
    endcase
    return b;
  endfunction

  // One Fibonacci step: shift left, feed back top XOR tap.
  function automatic logic [31:0] lfsr_step(input logic [31:0] s, input int n, input int tap);
    logic [31:0] r;
    logic fb;
    fb = s[n-1] ^ s[tap-1];
    r = {s[30:0], fb};
    r = r & ((32'd1 << n) - 32'd1);
    return r;
  endfunction

endpackage

// File: rtl/tpg_alarm_seq.sv
module tpg_alarm_seq #(
  parameter int PAYLOAD = 84,
  parameter int BLOCKS  = 8,
  parameter int SUBS    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  output logic bit_o,
  output logic [$clog2(PAYLOAD+1)-1:0] pos_o,
  output logic [$clog2(BLOCKS)-1:0]    blk_o,
  output logic [$clog2(SUBS)-1:0]      sub_o
);
  import tpg_pkg::*;

  localparam int KW = $clog2(PAYLOAD + 1);
  localparam int BW = $clog2(BLOCKS);
  localparam int SW = $clog2(SUBS);
  localparam logic [KW-1:0] K_LAST = KW'(PAYLOAD);
  localparam logic [BW-1:0] B_LAST = BW'(BLOCKS - 1);
  localparam logic [SW-1:0] S_LAST = SW'(SUBS - 1);

  logic [KW-1:0] k_q, k_cur;
  logic [BW-1:0] b_q, b_cur;
  logic [SW-1:0] s_q, s_cur;
  logic k_wrap, b_wrap;

  always_comb begin
    k_cur = restart ? '0 : k_q;
    b_cur = restart ? '0 : b_q;
    s_cur = restart ? '0 : s_q;
    k_wrap = (k_cur == K_LAST);
    b_wrap = (b_cur == B_LAST);
    if (k_cur == '0) bit_o = alarm_overhead(int'(s_cur), int'(b_cur));
    else             bit_o = k_cur[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q <= '0;
      b_q <= '0;
      s_q <= '0;
    end else if (advance) begin
      k_q <= k_wrap ? '0 : k_cur + 1'b1;
      if (k_wrap) begin
        b_q <= b_wrap ? '0 : b_cur + 1'b1;
        if (b_wrap) s_q <= (s_cur == S_LAST) ? '0 : s_cur + 1'b1;
        else        s_q <= s_cur;
      end else begin
        b_q <= b_cur;
        s_q <= s_cur;
      end
    end
  end

  assign pos_o = k_q;
  assign blk_o = b_q;
  assign sub_o = s_q;

endmodule

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int N   = 15,
  parameter int TAP = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  output logic bit_o,
  output logic zero_o
);
  import tpg_pkg::*;

  logic [N-1:0] st_q, st_cur;
  logic [31:0] nxt;

  always_comb begin
    st_cur = (restart || st_q == '0) ? '1 : st_q;
    bit_o  = st_cur[N-1];
    nxt    = lfsr_step(32'(st_cur), N, TAP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   st_q <= '1;
    else if (restart || advance)  st_q <= nxt[N-1:0];
  end

  assign zero_o = (st_q == '0);

endmodule

// File: rtl/tpg_top.sv
module tpg_top #(
  parameter int AIS_PAYLOAD = 84,
  parameter int AIS_BLOCKS  = 8,
  parameter int AIS_SUBS    = 7,
  parameter int PN_S_LEN    = 15,
  parameter int PN_S_TAP    = 14,
  parameter int PN_L_LEN    = 23,
  parameter int PN_L_TAP    = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gen_en,
  input  logic [1:0] pat_sel,
  input  logic [1:0] line_rate,
  input  logic       usr_bit,
  output logic       tx_bit
);
  import tpg_pkg::*;

  localparam int PN_LEN [2] = '{PN_S_LEN, PN_L_LEN};
  localparam int PN_TAP [2] = '{PN_S_TAP, PN_L_TAP};

  pat_mode_e mode, mode_q;
  logic      mode_chg;
  logic      alt_q;
  logic      alarm_bit;
  logic [1:0] pn_bit, pn_zero, pn_sel;
  logic      nxt_bit;
  logic [$clog2(AIS_PAYLOAD+1)-1:0] ais_pos;
  logic [$clog2(AIS_BLOCKS)-1:0]    ais_blk;
  logic [$clog2(AIS_SUBS)-1:0]      ais_sub;

  assign mode     = pick_mode(gen_en, pat_sel, line_rate);
  assign mode_chg = (mode != mode_q);
  assign pn_sel   = {mode == PAT_PN23, mode == PAT_PN15};

  tpg_alarm_seq #(.PAYLOAD(AIS_PAYLOAD), .BLOCKS(AIS_BLOCKS), .SUBS(AIS_SUBS)) u_alarm (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (mode_chg && mode == PAT_ALARM),
    .advance (mode == PAT_ALARM),
    .bit_o   (alarm_bit),
    .pos_o   (ais_pos),
    .blk_o   (ais_blk),
    .sub_o   (ais_sub)
  );

  for (genvar g = 0; g < 2; g++) begin : g_pn
    tpg_lfsr #(.N(PN_LEN[g]), .TAP(PN_TAP[g])) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (mode_chg && pn_sel[g]),
      .advance (pn_sel[g]),
      .bit_o   (pn_bit[g]),
      .zero_o  (pn_zero[g])
    );
  end

  always_comb begin
    case (mode)
      PAT_ONES:  nxt_bit = 1'b1;
      PAT_ALT:   nxt_bit = mode_chg ? 1'b1 : alt_q;
      PAT_ALARM: nxt_bit = alarm_bit;
      PAT_PN15:  nxt_bit = pn_bit[0];
      PAT_PN23:  nxt_bit = pn_bit[1];
      default:   nxt_bit = usr_bit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PAT_USER;
      alt_q  <= 1'b1;
      tx_bit <= 1'b0;
    end else begin
      mode_q <= mode;
      tx_bit <= nxt_bit;
      if (mode == PAT_ALT) alt_q <= ~nxt_bit;
    end
  end

endmodule

// File: rtl/tpg_chk.sv
module tpg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gen_en,
  input logic [1:0] pat_sel,
  input logic [1:0] line_rate,
  input logic       usr_bit,
  input logic       tx_bit,
  input tpg_pkg::pat_mode_e mode,
  input tpg_pkg::pat_mode_e mode_q,
  input logic [1:0] pn_zero,
  input logic [6:0] ais_pos,
  input logic [2:0] ais_blk,
  input logic [2:0] ais_sub
);
  import tpg_pkg::*;

  // R1: disabled generator forwards user data one edge later
  p_user_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> tx_bit == $past(usr_bit));

  // R2: ones select always yields a mark
  p_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && pat_sel == 2'd1) |=> tx_bit);

  // R3: alternation flips every bit while it stays selected
  p_alt_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PAT_ALT && mode_q == PAT_ALT) |=> tx_bit != $past(tx_bit));

  // R9: a fresh alarm starts with the subframe-1 lead bit (1)
  p_alarm_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PAT_ALARM && mode_q != PAT_ALARM) |=> tx_bit);

  // R9: shift registers never hold all zeros
  p_pn_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pn_zero == 2'b00);

  // R4: sequencer counters stay inside the multiframe
  p_alarm_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ais_pos <= 7'd84 && ais_sub <= 3'd6 && ais_blk <= 3'd7);

  // R10: output low while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_low_r10: assert (tx_bit == 1'b0);
    end
  end

endmodule

bind tpg_top tpg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gen_en    (gen_en),
  .pat_sel   (pat_sel),
  .line_rate (line_rate),
  .usr_bit   (usr_bit),
  .tx_bit    (tx_bit),
  .mode      (mode),
  .mode_q    (mode_q),
  .pn_zero   (pn_zero),
  .ais_pos   (ais_pos),
  .ais_blk   (ais_blk),
  .ais_sub   (ais_sub)
);

// File: tb/sim_tpg_top.sv
module sim_tpg_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gen_en = 1'b0;
  logic [1:0] pat_sel = 2'd0;
  logic [1:0] line_rate = 2'd0;
  logic       usr_bit = 1'b0;
  logic       tx_bit;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench model state
  int         prev_m = 0;
  int         al_pos = 0;
  int         alt_ph = 0;
  int         pn_n   = 0;
  logic [22:0] hist  = '0;

  always #4 clk = ~clk;   // 125 MHz

  tpg_top u0 (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .pat_sel(pat_sel),
    .line_rate(line_rate), .usr_bit(usr_bit), .tx_bit(tx_bit)
  );

  // 0 user, 1 ones, 2 alternation, 3 alarm, 4 pn15, 5 pn23
  function automatic int want_mode(logic en, logic [1:0] sel, logic [1:0] rate);
    if (!en || sel == 2'd0) return 0;
    if (sel == 2'd1) return 1;
    if (sel == 2'd2) return (rate == 2'd1) ? 3 : 2;
    return (rate == 2'd0) ? 5 : 4;
  endfunction

  // Alarm multiframe bit at flat index p (0..4759)
  function automatic logic alarm_ref(int p);
    int sub, rem, blk, k;
    sub = p / 680;
    rem = p % 680;
    blk = rem / 85;
    k   = rem % 85;
    if (k != 0) return ((k % 2) == 1);
    if (blk == 0) return (sub == 0 || sub == 1 || sub == 5);
    if (blk == 1 || blk == 7) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(logic exp, string tag);
    n_checks++;
    if (tx_bit !== exp) begin
      n_fail++;
      $display("FAIL %s: tx_bit=%0b expected=%0b at %0t", tag, tx_bit, exp, $time);
    end
  endtask

  // Drive one cycle (called at a negedge), predict, check at the next negedge.
  task automatic step(logic en, logic [1:0] sel, logic [1:0] rate, logic din);
    int m;
    bit rs;
    logic e;
    string tag;
    gen_en = en; pat_sel = sel; line_rate = rate; usr_bit = din;
    m  = want_mode(en, sel, rate);
    rs = (m != prev_m);
    prev_m = m;
    case (m)
      0: begin e = din; tag = en ? "R2" : "R1"; end
      1: begin e = 1'b1; tag = "R2"; end
      2: begin
        if (rs) alt_ph = 0;
        e = (alt_ph == 0);
        alt_ph ^= 1;
        tag = "R3";
      end
      3: begin
        if (rs) al_pos = 0;
        e = alarm_ref(al_pos);
        if (al_pos == 0) tag = "R4";
        else if ((al_pos % 85) == 0) tag = "R5";
        else tag = "R6";
        al_pos = (al_pos + 1) % 4760;
      end
      default: begin
        if (rs) begin pn_n = 0; hist = '0; end
        if (m == 4) begin
          e = (pn_n < 15) ? 1'b1 : (hist[14] ^ hist[13]);
          tag = "R7";
        end else begin
          e = (pn_n < 23) ? 1'b1 : (hist[22] ^ hist[17]);
          tag = "R8";
        end
        hist = {hist[21:0], e};
        pn_n++;
      end
    endcase
    if (rs) tag = "R9";
    @(negedge clk);
    check(e, tag);
  endtask

  task automatic run(int cycles, logic en, logic [1:0] sel, logic [1:0] rate);
    for (int i = 0; i < cycles; i++) step(en, sel, rate, 1'($urandom));
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'h1D5E_ED01));
    // R10: reset state
    repeat (3) @(negedge clk);
    gen_en = 1'b1; pat_sel = 2'd1;
    @(negedge clk);
    check(1'b0, "R10");
    gen_en = 1'b0; pat_sel = 2'd0;
    rst_n = 1'b1;
    @(negedge clk);

    run(40, 1'b0, 2'd3, 2'd0);          // R1: select ignored when disabled
    run(40, 1'b0, 2'd2, 2'd1);          // R1
    run(20, 1'b1, 2'd0, 2'd2);          // R2 user
    run(20, 1'b1, 2'd1, 2'd0);          // R2 ones
    run(30, 1'b1, 2'd2, 2'd0);          // R3 E3
    run(30, 1'b1, 2'd2, 2'd3);          // R3 rate 11 as STS-1
    run(4760 * 2 + 100, 1'b1, 2'd2, 2'd1); // R4/R5/R6 two multiframes + wrap
    // R9: rapid reselection restarts the alarm
    run(3, 1'b1, 2'd2, 2'd1);
    run(1, 1'b1, 2'd1, 2'd1);
    run(200, 1'b1, 2'd2, 2'd1);
    run(33000, 1'b1, 2'd3, 2'd1);       // R7 beyond one full period
    run(100, 1'b1, 2'd3, 2'd2);         // R7 via STS-1, no restart across rate
    run(4000, 1'b1, 2'd3, 2'd0);        // R8
    // constrained random segments
    for (int s = 0; s < 120; s++) begin
      int len;
      logic en;
      logic [1:0] sel, rate;
      len  = 1 + int'($urandom % 150);
      en   = ($urandom % 4) != 0;
      sel  = 2'($urandom);
      rate = 2'($urandom);
      run(len, en, sel, rate);
    end
    finish_up();
  end

endmodule